// File: doc/BRIEF.md
# Two-Wire Slave with Persistent Register Pointer

This block is a slave on a two-wire serial bus. It serves a small bank of byte-wide registers through a pointer register. SCL and SDA are sampled with the system clock and pass through two-flop synchronizers. Start and stop conditions and SCL edges are detected on the synchronized copies. The slave answers one fixed 7-bit address, and it drives SDA only by pulling it low through an open-drain enable.

After an address byte with the direction bit clear, the next byte selects a register. A pointer that names a register which does not exist ends the transaction at once. The slave keeps the pointer between transactions, so a read can follow without a new pointer byte. Within a transfer the working index steps forward after each byte, and at most two data bytes are served. The bank size, the set of registers that are populated and their reset values are parameters. A register that is left out of the map is not built at all.

Top module: `smb_ptr_slave`

## Requirements
- R1: A start (SDA falls while SCL is high) restarts address reception from any state, including in the middle of a transaction. A stop (SDA rises while SCL is high) returns the slave to idle with SDA released, from any point.
- R2: Every byte is eight bits, MSB first, followed by one acknowledge clock. The slave samples SDA on SCL rising edges and changes its SDA drive only after SCL falling edges, never while SCL is high.
- R3: The slave acknowledges (SDA low during the ninth clock) only an address byte whose upper seven bits equal 7'h58. Any other address is not acknowledged, and every later byte is ignored (not acknowledged) until the next start.
- R4: After the address byte with the direction bit (bit 0) equal to 0, the next byte is the pointer. A valid pointer is stored and acknowledged. A pointer is valid when its value is below NUM_REGS and the register is populated. By default registers 0, 1, 2, 4 and 5 are valid and 3 is absent.
- R5: An invalid pointer is not acknowledged and leaves the stored pointer unchanged. The remaining bytes of the transaction are ignored and not acknowledged until the next start.
- R6: In a write, data bytes go to pointer and then pointer+1, and each stored byte is acknowledged. A data byte aimed at an invalid register, or a third data byte, is not acknowledged and not stored, and the rest of the transaction is ignored.
- R7: A read (direction bit 1) returns the register the stored pointer selects, with no pointer byte needed, and then pointer+1. The stored pointer persists across transactions and is not advanced by this auto-increment.
- R8: In a read, a master acknowledge continues with the next byte, and a master not-acknowledge makes the slave release SDA until the next start. Bytes past the second, and bytes from an invalid register, read as 8'hFF with SDA released.
- R9: After reset, SDA is released, the pointer is 0, and each populated register i holds 8'hA0 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases the line |

## Verification
The hardest cases to reach from the ports are the internal aborts. Once the slave has gone quiet after a bad pointer, a rejected address or a rejected third byte, it does nothing that can be seen except fail to acknowledge. The stimulus keeps clocking bytes after each abort and checks that none is acknowledged. It then reads the bank back without a pointer byte, which shows through the normal read path that neither the pointer nor any register moved. Repeated starts and a stop placed partway through an address byte are produced by a bus-functional master that can emit partial bytes.

// File: rtl/smbp_pkg.sv
// Package: shared types for the two-wire pointer slave.
// Assumes: byte-wide registers and byte-wide pointer values.
package smbp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } link_state_t;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/smbp_sync_edge.sv
// Module: two-flop synchronizers for SCL and SDA, plus edge and
// start/stop detection on the synchronized copies.
// Assumes: bus lines idle high; the bus is slow next to clk.
module smbp_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    // Shift both lines through sync stages plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_in};
            sda_q <= {sda_q[1:0], sda_in};
        end
    end

    // Decode edges and bus conditions from stage 1 (now) vs stage 2 (before).
    always_comb begin
        sda_s    = sda_q[1];
        scl_rise = scl_q[1] & ~scl_q[2];
        scl_fall = ~scl_q[1] & scl_q[2];
        start_ev = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
        stop_ev  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
    end

endmodule

// File: rtl/smbp_regbank.sv
// Module: parameterized register bank with a populated-register map.
// Registers whose map bit is clear are not built and read as 8'hFF.
// Assumes: the writer only writes to addresses it has checked.
module smbp_regbank #(
    parameter int                    NUM_REGS   = 6,
    parameter logic [NUM_REGS-1:0]   VALID_MASK = 6'b110111,
    parameter logic [7:0]            RESET_BASE = 8'hA0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       rd_ok,
    input  logic [7:0] q_addr,
    output logic       q_ok
);
    logic [7:0] regs_q [NUM_REGS];
    logic       wr_ok;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (VALID_MASK[i]) begin : g_cell
            logic [7:0] cell_q;
            // Hold one populated register; reset to its base-plus-index value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= RESET_BASE + 8'(i);
                else if (wr_en && wr_addr == 8'(i))
                    cell_q <= wr_data;
            end
            assign regs_q[i] = cell_q;
        end else begin : g_hole
            assign regs_q[i] = smbp_pkg::IDLE_BYTE;
        end
    end

    // Look up read data and validity for the read and query ports.
    always_comb begin
        rd_data = smbp_pkg::IDLE_BYTE;
        rd_ok   = 1'b0;
        q_ok    = 1'b0;
        wr_ok   = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == 8'(i)) begin
                rd_data = regs_q[i];
                rd_ok   = VALID_MASK[i];
            end
            if (q_addr == 8'(i))  q_ok  = VALID_MASK[i];
            if (wr_addr == 8'(i)) wr_ok = VALID_MASK[i];
        end
    end

    // R6: the link never commits a write to an absent register.
    assert_write_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_ok);

endmodule

// File: rtl/smbp_link.sv
// Module: byte-level protocol engine. Shifts bits on SCL rises, updates
// its SDA drive on SCL falls, and sequences address, pointer, write and
// read phases with acknowledge handling.
// Assumes: events come from the synchronized bus; start/stop win over edges.
module smbp_link
    import smbp_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h58,
    parameter int         MAX_BYTES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    output logic [7:0] q_addr,
    input  logic       q_ok,
    output logic [7:0] rd_addr,
    input  logic [7:0] rd_data,
    input  logic       rd_ok,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_pull
);
    localparam int NB_W = $clog2(MAX_BYTES + 1);
    localparam logic [NB_W-1:0] NB_MAX = NB_W'(MAX_BYTES);

    link_state_t     st;
    logic [3:0]      cnt;
    logic [7:0]      shreg;
    logic [7:0]      tx;
    logic [7:0]      ptr;
    logic [7:0]      idx;
    logic [NB_W-1:0] nbytes;
    logic            rw;
    logic            mack;
    logic [7:0]      rd_byte;

    // Choose lookup addresses and the next byte to transmit.
    always_comb begin
        q_addr  = (st == ST_PTR) ? shreg : idx;
        rd_addr = (st == ST_ADDR_ACK) ? ptr : idx;
        rd_byte = (rd_ok && nbytes < NB_MAX) ? rd_data : IDLE_BYTE;
    end

    // Protocol sequencer: bus conditions first, then SCL rise and fall work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            tx       <= '0;
            ptr      <= '0;
            idx      <= '0;
            nbytes   <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_ev) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_ev) begin
                st       <= ST_ADDR;
                cnt      <= '0;
                nbytes   <= '0;
                sda_pull <= 1'b0;
            end else begin
                if (scl_rise) begin
                    shreg <= {shreg[6:0], sda_s};
                    if (cnt != 4'd8) cnt <= cnt + 4'd1;
                    if (st == ST_RDATA_ACK) mack <= ~sda_s;
                end
                if (scl_fall) begin
                    unique case (st)
                        ST_ADDR: if (cnt == 4'd8) begin
                            cnt <= '0;
                            if (shreg[7:1] == SLAVE_ADDR) begin
                                rw       <= shreg[0];
                                sda_pull <= 1'b1;
                                st       <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_ADDR_ACK: begin
                            cnt <= '0;
                            if (rw) begin
                                tx       <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                idx      <= ptr + 8'd1;
                                nbytes   <= NB_W'(1);
                                st       <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= ST_PTR;
                            end
                        end
                        ST_PTR: if (cnt == 4'd8) begin
                            cnt <= '0;
                            if (q_ok) begin
                                ptr      <= shreg;
                                idx      <= shreg;
                                sda_pull <= 1'b1;
                                st       <= ST_PTR_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_PTR_ACK: begin
                            cnt      <= '0;
                            nbytes   <= '0;
                            sda_pull <= 1'b0;
                            st       <= ST_WDATA;
                        end
                        ST_WDATA: if (cnt == 4'd8) begin
                            cnt <= '0;
                            if (q_ok && nbytes < NB_MAX) begin
                                wr_en    <= 1'b1;
                                wr_addr  <= idx;
                                wr_data  <= shreg;
                                idx      <= idx + 8'd1;
                                nbytes   <= nbytes + NB_W'(1);
                                sda_pull <= 1'b1;
                                st       <= ST_WDATA_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_WDATA_ACK: begin
                            cnt      <= '0;
                            sda_pull <= 1'b0;
                            st       <= ST_WDATA;
                        end
                        ST_RDATA: begin
                            if (cnt == 4'd8) begin
                                cnt      <= '0;
                                sda_pull <= 1'b0;
                                st       <= ST_RDATA_ACK;
                            end else begin
                                tx       <= {tx[6:0], 1'b0};
                                sda_pull <= ~tx[6];
                            end
                        end
                        ST_RDATA_ACK: begin
                            cnt <= '0;
                            if (mack) begin
                                tx       <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                idx      <= idx + 8'd1;
                                if (nbytes < NB_MAX) nbytes <= nbytes + NB_W'(1);
                                st       <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= ST_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R1: a start always lands in address reception with SDA released.
    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st == ST_ADDR) && !sda_pull);

    // R1: a stop always returns to idle with SDA released.
    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE) && !sda_pull);

    // R2: the SDA drive only moves after an SCL fall or a bus condition.
    assert_drive_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_ev || stop_ev));

    // R3: an acknowledge after an address byte needs a matching address.
    assert_addr_ack_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) && ($past(st) == ST_ADDR) |-> ($past(shreg[7:1]) == SLAVE_ADDR));

    // R5/R7: the stored pointer only changes when a pointer byte completes.
    assert_ptr_only_from_ptr_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past((st == ST_PTR) && scl_fall && q_ok));

endmodule

// File: rtl/smb_ptr_slave.sv
// Module: top of the two-wire pointer slave. Connects the bus
// synchronizer, the protocol engine and the register bank.
// Assumes: sda_pull_low drives an open-drain pad; an external pull-up holds SDA high.
module smb_ptr_slave #(
    parameter logic [6:0]          SLAVE_ADDR = 7'h58,
    parameter int                  NUM_REGS   = 6,
    parameter logic [NUM_REGS-1:0] VALID_MASK = 6'b110111,
    parameter logic [7:0]          RESET_BASE = 8'hA0,
    parameter int                  MAX_BYTES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull_low
);
    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0] q_addr, rd_addr, rd_data, wr_addr, wr_data;
    logic       q_ok, rd_ok, wr_en;

    smbp_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smbp_link #(
        .SLAVE_ADDR (SLAVE_ADDR),
        .MAX_BYTES  (MAX_BYTES)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .q_addr   (q_addr),
        .q_ok     (q_ok),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_ok    (rd_ok),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_pull (sda_pull_low)
    );

    smbp_regbank #(
        .NUM_REGS   (NUM_REGS),
        .VALID_MASK (VALID_MASK),
        .RESET_BASE (RESET_BASE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_ok   (rd_ok),
        .q_addr  (q_addr),
        .q_ok    (q_ok)
    );

endmodule

// File: tb/smb_ptr_slave_tb_top.sv
module smb_ptr_slave_tb_top;

    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_low;
    logic sda_bus;

    int checks = 0;
    int fails = 0;
    int viol = 0;
    bit done = 1'b0;

    logic [7:0] m [6];
    int mptr = 0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_low;

    smb_ptr_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low)
    );

    // R2 monitor: the slave drive must not move while SCL is high.
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && sda_pull_low !== prev_pull) viol++;
        prev_pull <= sda_pull_low;
    end

    // {op, ptr, d0, d1}: op 0 write two bytes, 1 set pointer then read, 2 read without pointer
    localparam logic [25:0] VEC [10] = '{
        {2'd0, 8'h00, 8'h11, 8'h22},
        {2'd1, 8'h00, 8'h00, 8'h00},
        {2'd0, 8'h04, 8'h44, 8'h55},
        {2'd1, 8'h04, 8'h00, 8'h00},
        {2'd0, 8'h01, 8'h66, 8'h77},
        {2'd2, 8'h00, 8'h00, 8'h00},
        {2'd1, 8'h05, 8'h00, 8'h00},
        {2'd0, 8'h02, 8'h88, 8'h99},
        {2'd1, 8'h02, 8'h00, 8'h00},
        {2'd2, 8'h00, 8'h00, 8'h00}
    };

    function automatic bit valid(int a);
        return a >= 0 && a < 6 && a != 3;
    endfunction

    function automatic logic [7:0] exp_rd(int p, int k);
        if (k >= 2 || !valid(p + k)) return 8'hFF;
        return m[p + k];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b0; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic tx_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qwait();
            scl = 1'b1;   qwait(); qwait();
            scl = 1'b0;   qwait();
        end
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        tx_bits(b, 8);
        sda_m = 1'b1; qwait();
        scl = 1'b1;   qwait();
        ack = (sda_bus == 1'b0);
        qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic rx_byte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait(); qwait();
            scl = 1'b1; qwait();
            b[i] = sda_bus;
            qwait();
            scl = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    // Write ptr then bytes; acknowledge expectations come from the model.
    task automatic do_write(input int p, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int n);
        bit ack, alive, e;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        tx_byte(8'hB0, ack); chk("R3", ack, 1, "address ack on write");
        tx_byte(8'(p), ack); chk("R4", ack, valid(p), "pointer ack");
        alive = valid(p);
        if (alive) mptr = p;
        for (int k = 0; k < n; k++) begin
            tx_byte(d[k], ack);
            e = alive && k < 2 && valid(p + k);
            chk("R6", ack, e, "write data ack");
            if (e) m[p + k] = d[k];
            alive = e;
        end
        bus_stop();
    endtask

    // Read n bytes, optionally after a pointer set with a repeated start.
    task automatic do_read(input bit setp, input int p, input int n, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        if (setp) begin
            tx_byte(8'hB0, ack); chk(req, ack, 1, "address ack before read");
            tx_byte(8'(p), ack); chk("R4", ack, valid(p), "pointer ack before read");
            if (valid(p)) mptr = p;
            bus_start();
        end
        tx_byte(8'hB1, ack); chk("R3", ack, 1, "read address ack");
        for (int k = 0; k < n; k++) begin
            rx_byte(b, k != n - 1);
            chk(req, b, exp_rd(mptr, k), "read byte");
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 6; i++) m[i] = 8'hA0 + 8'(i);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9", sda_pull_low, 0, "SDA released after reset");
        // R9 / R7: reset pointer 0, reset register values, no pointer byte
        do_read(1'b0, 0, 2, "R9");

        for (int v = 0; v < 10; v++) begin
            logic [1:0] op;
            int p;
            op = VEC[v][25:24];
            p  = int'(VEC[v][23:16]);
            if (op == 2'd0) do_write(p, VEC[v][15:8], VEC[v][7:0], 8'h00, 2);
            else if (op == 2'd1) do_read(1'b1, p, 2, "R7");
            else do_read(1'b0, 0, 2, "R7");
        end

        // R3: foreign address is refused and the rest ignored
        bus_start();
        tx_byte(8'hB2, ack); chk("R3", ack, 0, "foreign address nack");
        tx_byte(8'h00, ack); chk("R3", ack, 0, "byte after foreign address");
        bus_stop();
        do_read(1'b0, 0, 2, "R3");

        // R5: invalid pointers (absent register and out of range)
        bus_start();
        tx_byte(8'hB0, ack); chk("R5", ack, 1, "address ack");
        tx_byte(8'h03, ack); chk("R5", ack, 0, "absent register pointer nack");
        tx_byte(8'h12, ack); chk("R5", ack, 0, "data after bad pointer");
        bus_stop();
        do_write(8'h80, 8'h13, 8'h00, 8'h00, 1);
        do_read(1'b0, 0, 2, "R5");

        // R6: third write byte refused and not stored
        do_write(0, 8'hC1, 8'hC2, 8'hC3, 3);
        do_read(1'b1, 2, 2, "R6");

        // R8: third read byte and invalid neighbour read as FF
        do_read(1'b1, 0, 3, "R8");

        // R8: after master nack the slave stays released
        bus_start();
        tx_byte(8'hB1, ack); chk("R8", ack, 1, "read address ack");
        rx_byte(b, 1'b0); chk("R8", b, exp_rd(mptr, 0), "single byte read");
        chk("R8", sda_pull_low, 0, "released after master nack");
        rx_byte(b, 1'b0); chk("R8", b, 8'hFF, "bus idle after nack");
        bus_stop();

        // R1: repeated start in the middle of a write
        bus_start();
        tx_byte(8'hB0, ack);
        tx_byte(8'h04, ack); chk("R1", ack, 1, "pointer ack");
        tx_byte(8'h5A, ack); chk("R1", ack, 1, "data ack");
        m[4] = 8'h5A; mptr = 4;
        bus_start();
        tx_byte(8'hB1, ack); chk("R1", ack, 1, "address ack after repeated start");
        rx_byte(b, 1'b1); chk("R1", b, m[4], "first byte after repeated start");
        rx_byte(b, 1'b0); chk("R1", b, m[5], "second byte after repeated start");
        bus_stop();

        // R1: stop partway through an address byte
        bus_start();
        tx_bits(8'hB1, 4);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R1", sda_pull_low, 0, "released after early stop");
        do_read(1'b0, 0, 2, "R1");

        chk("R2", viol, 0, "slave drive changes while SCL high");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule